// File: doc/BRIEF.md
# Caller-ID Character Capture

This block turns the serial character stream of a caller-ID receiver into bytes for a host. The receiver drives a data line, a gated data clock and a word-ready strobe. None of them is related to the system clock. The block brings all three into the system clock domain. It shifts the data line into a character register on each rising edge of the data clock, and when word-ready rises it hands the character to the host with a one-cycle valid pulse. The host uses that pulse as an interrupt.

The data clock pulses only for the eight character bits of each ten-bit word. It stays high through the start and stop bits, so no framing logic is needed. Word-ready marks each word boundary. Each delivered byte is marked as unread until the host acknowledges it. If a new word arrives while a byte is still unread, an overrun flag is raised.

Top module: `cid_word_capture`

## Requirements
- R1: While reset is asserted, `char_o` is 0, `char_valid_o` is 0 and `overrun_o` is 0.
- R2: Bits are taken least-significant first. After eight data-clock rising edges, bit k of the delivered character is the data level present at the k-th of those edges (k = 0 for the first).
- R3: A shift happens only on a rising edge of the data clock. Changes on the data line while the data clock holds high or low, as during start and stop bits, do not alter the delivered character.
- R4: A rising edge of word-ready loads the last shifted character onto `char_o` and pulses `char_valid_o` high for exactly one cycle. An input change driven between two system clock edges appears at the third rising edge after that change.
- R5: `char_o` holds its value between word-ready events, even while new bits are being shifted in.
- R6: Word-ready held high for many cycles produces only one valid pulse.
- R7: A word-ready rise while the previous byte is unacknowledged sets `overrun_o` together with the valid pulse. The new character still replaces the old one.
- R8: A high `host_ack_i` sampled at a system clock edge clears `overrun_o` and the unread state at that edge. A following word then delivers without overrun.
- R9: When more than eight data-clock rises occur between word-ready events, only the last eight bits are delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_data_i | input | 1 | Serial character data from the receiver |
| ser_clk_i | input | 1 | Gated data clock; a rising edge shifts one bit |
| word_rdy_i | input | 1 | Word-ready strobe; a rising edge delivers the character |
| host_ack_i | input | 1 | Host acknowledge of the delivered byte (system domain) |
| char_o | output | 8 | Last delivered character |
| char_valid_o | output | 1 | One-cycle pulse when a character is delivered |
| overrun_o | output | 1 | A character was delivered over an unread one |

## Verification
All three receiver inputs pass through two synchronising flops and one edge-detect flop. A level changed between clock edges therefore acts at the third following rising edge. That edge is where a bit enters the shift register and where `char_o`, `char_valid_o` and `overrun_o` change. The acknowledge input is not synchronised, so it acts at the next edge. The bench drives every input on a falling edge. It counts exactly three rising edges after raising word-ready and samples on the falling edge after them, where it expects the valid pulse. It samples again one cycle later, where it expects the pulse to be gone. Bits are given several cycles of settling on each side of a data-clock rise, so each shift lands well inside the bench's bit window.

// File: rtl/cidcap_pkg.sv
package cidcap_pkg;
  localparam int unsigned CHAR_W_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;
endpackage

// File: rtl/cidcap_sync.sv
module cidcap_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cidcap_rise.sv
module cidcap_rise #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cidcap_shift.sv
module cidcap_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {bit_in, sh_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word = sh_q;
endmodule

// File: rtl/cidcap_deliver.sv
module cidcap_deliver #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         ack,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] char_out,
  output logic         valid_out,
  output logic         ovr_out
);
  logic [W-1:0] char_q, char_d;
  logic         vld_q, vld_d;
  logic         pend_q, pend_d;
  logic         ovr_q, ovr_d;

  always_comb begin
    char_d = char_q;
    if (load) char_d = word_in;
    vld_d  = load;
    pend_d = load | (pend_q & ~ack);
    ovr_d  = (ovr_q & ~ack) | (load & pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_q <= '0;
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      char_q <= char_d;
      vld_q  <= vld_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  assign char_out  = char_q;
  assign valid_out = vld_q;
  assign ovr_out   = ovr_q;
endmodule

// File: rtl/cid_word_capture.sv
module cid_word_capture
  import cidcap_pkg::*;
#(
  parameter int unsigned CHAR_W      = CHAR_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              word_rdy_i,
  input  logic              host_ack_i,
  output logic [CHAR_W-1:0] char_o,
  output logic              char_valid_o,
  output logic              overrun_o
);
  localparam int unsigned NLINES = 3;

  logic              rst_n;
  logic [1:0]        rst_sh_q;
  logic [NLINES-1:0] raw_lines, syn_lines;
  logic [1:0]        rises;
  logic [CHAR_W-1:0] shift_word;

  // reset: asserts asynchronously, releases after two clean edges
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sh_q <= 2'b00;
    else         rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n = rst_sh_q[1];

  // line order: [2]=word ready, [1]=data clock, [0]=data
  assign raw_lines = {word_rdy_i, ser_clk_i, ser_data_i};

  cidcap_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(syn_lines)
  );

  cidcap_rise #(.W(2)) u_rise (
    .clk(clk), .rst_n(rst_n), .lvl(syn_lines[2:1]), .rise(rises)
  );

  cidcap_shift #(.W(CHAR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(rises[0]),
    .bit_in(syn_lines[0]), .word(shift_word)
  );

  cidcap_deliver #(.W(CHAR_W)) u_deliver (
    .clk(clk), .rst_n(rst_n), .load(rises[1]), .ack(host_ack_i),
    .word_in(shift_word), .char_out(char_o),
    .valid_out(char_valid_o), .ovr_out(overrun_o)
  );
endmodule

// File: rtl/cid_word_capture_chk.sv
module cid_word_capture_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              host_ack_i,
  input logic [CHAR_W-1:0] char_o,
  input logic              char_valid_o,
  input logic              overrun_o
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_ni |-> (!char_valid_o && !overrun_o && char_o == '0));

  // R4 / R6
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o);

  // R5
  a_r5_char_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(char_o) |-> char_valid_o);

  // R7
  a_r7_overrun_with_load: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(overrun_o) |-> char_valid_o);

  // R8
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    host_ack_i |=> !overrun_o);
endmodule

bind cid_word_capture cid_word_capture_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .host_ack_i(host_ack_i), .char_o(char_o),
  .char_valid_o(char_valid_o), .overrun_o(overrun_o)
);

// File: tb/sim_cid_word_capture.sv
`timescale 1ns/100ps
module sim_cid_word_capture;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       ser_data_i, ser_clk_i, word_rdy_i, host_ack_i;
  logic [7:0] char_o;
  logic       char_valid_o, overrun_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_shift = 8'h00;
  logic [7:0] exp_char  = 8'h00;
  logic       exp_pend  = 1'b0;
  logic       exp_ovr   = 1'b0;

  always #2.5 clk = ~clk;

  cid_word_capture u0 (
    .clk(clk), .rst_ni(rst_ni), .ser_data_i(ser_data_i), .ser_clk_i(ser_clk_i),
    .word_rdy_i(word_rdy_i), .host_ack_i(host_ack_i), .char_o(char_o),
    .char_valid_o(char_valid_o), .overrun_o(overrun_o)
  );

  function automatic logic [7:0] push_bit(logic [7:0] cur, logic b);
    return {b, cur[7:1]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_clk_i = 1'b0; ser_data_i = b;
    idle(4);
    ser_clk_i = 1'b1;
    exp_shift = push_bit(exp_shift, b);
    idle(4);
  endtask

  // start bit, bits, stop bit; data toggles while data clock stays high
  task automatic send_word(input logic [7:0] v, input int extra);
    @(negedge clk); ser_data_i = 1'b0; idle(3);
    ser_data_i = 1'b1; idle(2); ser_data_i = 1'b0; idle(2);
    for (int i = 0; i < extra; i++) send_bit(~v[i]);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    @(negedge clk); ser_data_i = 1'b1; idle(3);
    ser_data_i = 1'b0; idle(2); ser_data_i = 1'b1; idle(3);
  endtask

  task automatic deliver(input int hold, input string tag);
    @(negedge clk); word_rdy_i = 1'b1;
    exp_ovr  = exp_ovr | exp_pend;
    exp_pend = 1'b1;
    exp_char = exp_shift;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(char_valid_o == 1'b1, {tag, " R4 valid due"}, char_valid_o, 1);
    check(char_o == exp_char, {tag, " R2 R9 char"}, char_o, exp_char);
    check(overrun_o == exp_ovr, {tag, " R7 overrun"}, overrun_o, exp_ovr);
    @(negedge clk);
    check(char_valid_o == 1'b0, {tag, " R4 valid one cycle"}, char_valid_o, 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(char_valid_o == 1'b0, {tag, " R6 no repeat"}, char_valid_o, 0);
    end
    word_rdy_i = 1'b0;
    idle(4);
  endtask

  task automatic do_ack();
    @(negedge clk); host_ack_i = 1'b1;
    @(negedge clk); host_ack_i = 1'b0;
    exp_pend = 1'b0; exp_ovr = 1'b0;
    check(overrun_o == 1'b0, "R8 ack clears", overrun_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; ser_data_i = 1'b0; ser_clk_i = 1'b1;
    word_rdy_i = 1'b0; host_ack_i = 1'b0;
    idle(4);
    check(char_o == 8'h00, "R1 char", char_o, 0);
    check(char_valid_o == 1'b0, "R1 valid", char_valid_o, 0);
    check(overrun_o == 1'b0, "R1 overrun", overrun_o, 0);
    rst_ni = 1'b1;
    idle(6);

    // R2 bit order, R3 glitches on data while clock high
    send_word(8'h01, 0); deliver(6, "d01"); do_ack();
    send_word(8'h80, 0); deliver(6, "d80"); do_ack();
    send_word(8'hA5, 0); deliver(20, "dA5 R3");
    // R5: shifting new bits must not touch the delivered character
    send_word(8'h3C, 0);
    check(char_o == 8'hA5, "R5 hold", char_o, 8'hA5);
    // R7: deliver without acknowledging the previous one
    deliver(4, "ovr");
    do_ack();
    // R8: after ack, next word free of overrun; R9 extra bits
    send_word(8'hC3, 2); deliver(4, "post-ack R9");
    do_ack();

    for (int n = 0; n < 40; n++) begin
      logic [7:0] v;
      v = 8'($urandom);
      send_word(v, int'($urandom % 3));
      check(char_o == exp_char, "R5 hold rnd", char_o, exp_char);
      deliver(int'($urandom % 8), "rnd");
      if ($urandom % 2 == 0) do_ack();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule